// File: doc/BRIEF.md
# Indirect Classifier Table Loader

This block gives a host a narrow register window through which it fills the internal tables of a packet classifier. The host stages an address word and as many data words as the target entry needs. It then writes a command word and polls a status register until the done bits appear. The address word carries an entry index in its low bits and a region code above them. The region code names both the table and, for tables that each parser port owns a private copy of, the port number.

Per-port tables are the sideband table (one word per entry), the indirection table (one word per entry: queue id and pool selects) and the hash key (one four-word entry). Their region code is the table type plus four times the port number. The tree-node table (17 words per entry) and the result table (6 words per entry) exist once for all ports and have fixed region codes. Once a command is accepted, the controller copies the staged words into the selected table one word per clock. It reports completion only after the last word is stored. Commands that cannot be carried out still complete, but leave the tables untouched and raise a sticky error flag.

A read-side lookup port is included so that the logic that uses the tables can fetch one word. The lookup returns that word one clock after the request.

Top module: `itw_ctrl`

## Requirements
- R1: After reset the status register (offset 2) and the address register (offset 0) read as zero, with busy (status bit 8) and error (status bit 9) clear.
- R2: A region code below 32 selects a per-port table, with bits [1:0] giving the type (0 sideband, 1 indirection, 2 hash key, 3 none) and bits [4:2] the port, so the code equals type plus four times port. A write reaches only that port's copy. The address word holds the index in bits [9:0] and the region code in bits [15:10].
- R3: Region code 32 selects the shared tree-node table and code 33 the shared result table, independent of any port.
- R4: The controller stores word k of an entry from data register k (offset 4+k), one word per clock in ascending order. It transfers 1, 1, 4, 17 and 6 words for sideband, indirection, hash key, tree node and result entries.
- R5: A command write (offset 1) with code 1 sets busy at the accepting clock edge. The status done bits [3:0] show the command code exactly N clock edges later, where N is the entry's word count, and busy clears at that same edge.
- R6: The done bits clear at the clock edge that accepts the next command.
- R7: A command write while busy is ignored, sets the error bit, and leaves the running transfer unchanged.
- R8: A region code that selects no table, or an index at or beyond the table depth, completes one clock edge after acceptance with done set and the error bit raised, and writes nothing.
- R9: A command code other than 1 completes one clock edge after acceptance with that code in the done bits and the error bit raised, and writes nothing.
- R10: The error bit stays set until the host writes the status register with bit 9 set; a status write with bit 9 clear has no effect.
- R11: Writes to the address and data registers while busy are ignored.
- R12: A lookup of (region, index, word) returns the stored word on the lookup data output one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_off | input | 5 | Register word offset for write and read |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational on host_off |
| lk_region | input | 6 | Lookup region code |
| lk_index | input | IDX_W (10) | Lookup entry index |
| lk_word | input | 5 | Lookup word within the entry |
| lk_data | output | 32 | Lookup result, one clock after the request |

## Verification
The checker watches, on every cycle, that done carries the accepted code right after the transfer's final cycle and that acceptance clears it. It also checks that words advance one per cycle, that staged address contents hold still while busy, that a command arriving while busy raises the error, and that the error only falls after a clearing write. The exact completion latency for each table, the separation between port copies, the shared tables, and the fact that rejected commands or late data writes leave table contents intact can only be shown by the bench's scenarios, which read the tables back through the lookup port.

// File: rtl/itw_pkg.sv
// Shared constants and types for the indirect table write controller.
// Assumes 32-bit host registers and a five-bit register offset space.
package itw_pkg;
    localparam int RGN_W  = 6;
    localparam int OFF_W  = 5;
    localparam int WSEL_W = 5;
    localparam int DATA_REGS = 17;

    localparam int W_SB   = 1;
    localparam int W_IDT  = 1;
    localparam int W_KEY  = 4;
    localparam int W_NODE = 17;
    localparam int W_RES  = 6;

    localparam logic [OFF_W-1:0] OFF_ADDR  = 5'd0;
    localparam logic [OFF_W-1:0] OFF_CMD   = 5'd1;
    localparam logic [OFF_W-1:0] OFF_STAT  = 5'd2;
    localparam logic [OFF_W-1:0] OFF_DATA0 = 5'd4;

    localparam logic [3:0] CMD_WRITE = 4'h1;
    localparam logic [RGN_W-1:0] RC_NODE = 6'd32;
    localparam logic [RGN_W-1:0] RC_RES  = 6'd33;
    localparam int STAT_BUSY_BIT = 8;
    localparam int STAT_ERR_BIT  = 9;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_SB   = 3'd1,
        TGT_IDT  = 3'd2,
        TGT_KEY  = 3'd3,
        TGT_NODE = 3'd4,
        TGT_RES  = 3'd5
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [2:0]  port;
        logic [4:0]  nwords;
    } dec_t;
endpackage

// File: rtl/itw_decode.sv
// Region decoder: turns a region code and entry index into a table target,
// a port number and the entry word count. Assumes NPORTS <= 8.
// An unknown code, an absent port or an index past the depth gives TGT_NONE.
module itw_decode import itw_pkg::*; #(
    parameter int NPORTS     = 2,
    parameter int IDX_W      = 10,
    parameter int SB_DEPTH   = 4,
    parameter int IDT_DEPTH  = 16,
    parameter int KEY_DEPTH  = 1,
    parameter int NODE_DEPTH = 8,
    parameter int RES_DEPTH  = 8
) (
    input  logic [RGN_W-1:0] region,
    input  logic [IDX_W-1:0] index,
    output dec_t             dec
);
    logic [2:0] port_f;
    logic [1:0] type_f;
    int         idx_i;

    assign port_f = region[4:2];
    assign type_f = region[1:0];
    assign idx_i  = int'(index);

    // Classify the region code as per-port, shared or invalid
    always_comb begin
        dec = '{tgt: TGT_NONE, port: 3'd0, nwords: 5'd0};
        if (!region[RGN_W-1]) begin
            if (int'(port_f) < NPORTS) begin
                case (type_f)
                    2'd0: if (idx_i < SB_DEPTH)  dec = '{TGT_SB,  port_f, 5'(W_SB)};
                    2'd1: if (idx_i < IDT_DEPTH) dec = '{TGT_IDT, port_f, 5'(W_IDT)};
                    2'd2: if (idx_i < KEY_DEPTH) dec = '{TGT_KEY, port_f, 5'(W_KEY)};
                    default: dec = '{tgt: TGT_NONE, port: 3'd0, nwords: 5'd0};
                endcase
            end
        end else begin
            if (region == RC_NODE && idx_i < NODE_DEPTH)
                dec = '{TGT_NODE, 3'd0, 5'(W_NODE)};
            else if (region == RC_RES && idx_i < RES_DEPTH)
                dec = '{TGT_RES, 3'd0, 5'(W_RES)};
        end
    end
endmodule

// File: rtl/itw_mem.sv
// Behavioural table RAM: DEPTH entries of WORDS 32-bit words, one write
// port taking one word per clock and one registered read port.
// Assumes out-of-range accesses are filtered upstream; they are also
// dropped here and read back as zero.
module itw_mem #(
    parameter int WORDS = 4,
    parameter int DEPTH = 4,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [4:0]       wword,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    input  logic [4:0]       rword,
    output logic [31:0]      rdata
);
    localparam int SIZE = DEPTH * WORDS;
    localparam int AW   = (SIZE > 1) ? $clog2(SIZE) : 1;

    logic [31:0]   store [SIZE];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          w_in;
    logic          r_in;

    assign w_in  = (int'(widx) < DEPTH) && (int'(wword) < WORDS);
    assign r_in  = (int'(ridx) < DEPTH) && (int'(rword) < WORDS);
    assign waddr = AW'(int'(widx) * WORDS + int'(wword));
    assign raddr = AW'(int'(ridx) * WORDS + int'(rword));

    // Commit one word per clock when enabled
    always_ff @(posedge clk) begin
        if (we && w_in)
            store[waddr] <= wdata;
    end

    // Registered read, zero outside the table
    always_ff @(posedge clk) begin
        rdata <= r_in ? store[raddr] : 32'd0;
    end
endmodule

// File: rtl/itw_regs.sv
// Host register window: address, command, status and staged data words.
// Assumes one host write per clock; reads are combinational on host_off.
// Address and data are frozen while the engine is busy.
module itw_regs import itw_pkg::*; #(
    parameter int IDX_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_wr,
    input  logic [OFF_W-1:0]               host_off,
    input  logic [31:0]                    host_wdata,
    output logic [31:0]                    host_rdata,
    input  logic                           eng_busy,
    input  logic                           eng_fin,
    input  logic                           eng_fin_err,
    output logic                           start,
    output logic [IDX_W+RGN_W-1:0]         addr_q,
    output logic [DATA_REGS-1:0][31:0]     data_q,
    output logic [3:0]                     cmd_code,
    output logic [3:0]                     done_bits,
    output logic                           err_flag
);
    localparam int AQ_W = IDX_W + RGN_W;

    logic cmd_hit;
    logic stage_ok;

    assign cmd_hit  = host_wr && (host_off == OFF_CMD);
    assign start    = cmd_hit && !eng_busy;
    assign stage_ok = host_wr && !eng_busy;

    // Capture the indirect address while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (stage_ok && host_off == OFF_ADDR)
            addr_q <= host_wdata[AQ_W-1:0];
    end

    // Capture staged data words while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (stage_ok) begin
            for (int i = 0; i < DATA_REGS; i++)
                if (host_off == OFF_W'(int'(OFF_DATA0) + i))
                    data_q[i] <= host_wdata;
        end
    end

    // Track the accepted command and its done bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code  <= 4'd0;
            done_bits <= 4'd0;
        end else if (start) begin
            cmd_code  <= host_wdata[3:0];
            done_bits <= 4'd0;
        end else if (eng_fin) begin
            done_bits <= cmd_code;
        end
    end

    // Sticky error: set on rejected commands, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if ((cmd_hit && eng_busy) || eng_fin_err)
            err_flag <= 1'b1;
        else if (host_wr && host_off == OFF_STAT && host_wdata[STAT_ERR_BIT])
            err_flag <= 1'b0;
    end

    // Register read multiplexer
    always_comb begin
        host_rdata = 32'd0;
        if (host_off == OFF_ADDR)
            host_rdata = 32'(addr_q);
        else if (host_off == OFF_CMD)
            host_rdata = {28'd0, cmd_code};
        else if (host_off == OFF_STAT)
            host_rdata = {22'd0, err_flag, eng_busy, 4'd0, done_bits};
        else if (host_off >= OFF_DATA0 &&
                 int'(host_off) < int'(OFF_DATA0) + DATA_REGS)
            host_rdata = data_q[host_off - OFF_DATA0];
    end
endmodule

// File: rtl/itw_engine.sv
// Transfer engine: after a start pulse, walks the entry word counter one
// word per clock and flags completion in the cycle of the last word.
// Assumes op_ok and nwords are valid in the start cycle; a rejected
// operation finishes after one cycle with an error and no write.
module itw_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_ok,
    input  logic [4:0] nwords,
    output logic       busy,
    output logic       wr_en,
    output logic [4:0] wr_word,
    output logic       fin,
    output logic       fin_err
);
    logic       ok_q;
    logic [4:0] last_q;

    assign wr_en   = busy && ok_q;
    assign fin     = busy && (!ok_q || wr_word == last_q);
    assign fin_err = fin && !ok_q;

    // Sequence the transfer from start to final word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ok_q    <= 1'b0;
            wr_word <= 5'd0;
            last_q  <= 5'd0;
        end else if (start) begin
            busy    <= 1'b1;
            ok_q    <= op_ok;
            wr_word <= 5'd0;
            last_q  <= op_ok ? nwords - 5'd1 : 5'd0;
        end else if (fin) begin
            busy    <= 1'b0;
            wr_word <= 5'd0;
        end else if (busy) begin
            wr_word <= wr_word + 5'd1;
        end
    end
endmodule

// File: rtl/itw_ctrl.sv
// Indirect table write controller top: register window, region decode,
// transfer engine, per-port and shared table RAMs, and a lookup port.
// Assumes the host polls status for completion; lookups have one cycle
// of latency and read zero for unknown regions or out-of-range words.
module itw_ctrl import itw_pkg::*; #(
    parameter int NPORTS     = 2,
    parameter int IDX_W      = 10,
    parameter int SB_DEPTH   = 4,
    parameter int IDT_DEPTH  = 16,
    parameter int KEY_DEPTH  = 1,
    parameter int NODE_DEPTH = 8,
    parameter int RES_DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [RGN_W-1:0]  lk_region,
    input  logic [IDX_W-1:0]  lk_index,
    input  logic [WSEL_W-1:0] lk_word,
    output logic [31:0]       lk_data
);
    logic [IDX_W+RGN_W-1:0]       addr_q;
    logic [DATA_REGS-1:0][31:0]   data_q;
    logic                         start;
    logic [3:0]                   cmd_code;
    logic [3:0]                   done_bits;
    logic                         err_flag;
    logic                         eng_busy;
    logic                         eng_fin;
    logic                         eng_fin_err;
    logic                         wr_en;
    logic [4:0]                   wr_word;
    logic [31:0]                  wr_data;
    logic                         op_ok;
    dec_t                         wdec;
    dec_t                         ldec;
    tgt_e                         lk_tgt_q;
    logic [2:0]                   lk_port_q;
    logic                         lk_ok_q;
    logic [31:0]                  sb_rd   [NPORTS];
    logic [31:0]                  idt_rd  [NPORTS];
    logic [31:0]                  key_rd  [NPORTS];
    logic [31:0]                  node_rd;
    logic [31:0]                  res_rd;

    itw_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_busy(eng_busy), .eng_fin(eng_fin), .eng_fin_err(eng_fin_err),
        .start(start), .addr_q(addr_q), .data_q(data_q),
        .cmd_code(cmd_code), .done_bits(done_bits), .err_flag(err_flag)
    );

    itw_decode #(
        .NPORTS(NPORTS), .IDX_W(IDX_W), .SB_DEPTH(SB_DEPTH),
        .IDT_DEPTH(IDT_DEPTH), .KEY_DEPTH(KEY_DEPTH),
        .NODE_DEPTH(NODE_DEPTH), .RES_DEPTH(RES_DEPTH)
    ) u_wdec (
        .region(addr_q[IDX_W+RGN_W-1:IDX_W]),
        .index(addr_q[IDX_W-1:0]),
        .dec(wdec)
    );

    itw_decode #(
        .NPORTS(NPORTS), .IDX_W(IDX_W), .SB_DEPTH(SB_DEPTH),
        .IDT_DEPTH(IDT_DEPTH), .KEY_DEPTH(KEY_DEPTH),
        .NODE_DEPTH(NODE_DEPTH), .RES_DEPTH(RES_DEPTH)
    ) u_ldec (
        .region(lk_region),
        .index(lk_index),
        .dec(ldec)
    );

    // The command code is taken from the bus in the accepting cycle
    assign op_ok   = (host_wdata[3:0] == CMD_WRITE) && (wdec.tgt != TGT_NONE);
    assign wr_data = data_q[wr_word];

    itw_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .op_ok(op_ok),
        .nwords(wdec.nwords), .busy(eng_busy), .wr_en(wr_en),
        .wr_word(wr_word), .fin(eng_fin), .fin_err(eng_fin_err)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        itw_mem #(.WORDS(W_SB), .DEPTH(SB_DEPTH), .IDX_W(IDX_W)) u_sb (
            .clk(clk),
            .we(wr_en && wdec.tgt == TGT_SB && wdec.port == 3'(p)),
            .widx(addr_q[IDX_W-1:0]), .wword(wr_word), .wdata(wr_data),
            .ridx(lk_index), .rword(lk_word), .rdata(sb_rd[p])
        );
        itw_mem #(.WORDS(W_IDT), .DEPTH(IDT_DEPTH), .IDX_W(IDX_W)) u_idt (
            .clk(clk),
            .we(wr_en && wdec.tgt == TGT_IDT && wdec.port == 3'(p)),
            .widx(addr_q[IDX_W-1:0]), .wword(wr_word), .wdata(wr_data),
            .ridx(lk_index), .rword(lk_word), .rdata(idt_rd[p])
        );
        itw_mem #(.WORDS(W_KEY), .DEPTH(KEY_DEPTH), .IDX_W(IDX_W)) u_key (
            .clk(clk),
            .we(wr_en && wdec.tgt == TGT_KEY && wdec.port == 3'(p)),
            .widx(addr_q[IDX_W-1:0]), .wword(wr_word), .wdata(wr_data),
            .ridx(lk_index), .rword(lk_word), .rdata(key_rd[p])
        );
    end

    itw_mem #(.WORDS(W_NODE), .DEPTH(NODE_DEPTH), .IDX_W(IDX_W)) u_node (
        .clk(clk), .we(wr_en && wdec.tgt == TGT_NODE),
        .widx(addr_q[IDX_W-1:0]), .wword(wr_word), .wdata(wr_data),
        .ridx(lk_index), .rword(lk_word), .rdata(node_rd)
    );

    itw_mem #(.WORDS(W_RES), .DEPTH(RES_DEPTH), .IDX_W(IDX_W)) u_res (
        .clk(clk), .we(wr_en && wdec.tgt == TGT_RES),
        .widx(addr_q[IDX_W-1:0]), .wword(wr_word), .wdata(wr_data),
        .ridx(lk_index), .rword(lk_word), .rdata(res_rd)
    );

    // Register the lookup decode alongside the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_tgt_q  <= TGT_NONE;
            lk_port_q <= 3'd0;
            lk_ok_q   <= 1'b0;
        end else begin
            lk_tgt_q  <= ldec.tgt;
            lk_port_q <= ldec.port;
            lk_ok_q   <= (ldec.tgt != TGT_NONE) && (lk_word < ldec.nwords);
        end
    end

    // Select the lookup result from the addressed table
    always_comb begin
        lk_data = 32'd0;
        if (lk_ok_q) begin
            case (lk_tgt_q)
                TGT_NODE: lk_data = node_rd;
                TGT_RES:  lk_data = res_rd;
                default: begin
                    for (int p = 0; p < NPORTS; p++) begin
                        if (3'(p) == lk_port_q) begin
                            if (lk_tgt_q == TGT_SB)  lk_data = sb_rd[p];
                            if (lk_tgt_q == TGT_IDT) lk_data = idt_rd[p];
                            if (lk_tgt_q == TGT_KEY) lk_data = key_rd[p];
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/itw_ctrl_chk.sv
// Protocol checker for itw_ctrl, attached by bind below.
module itw_ctrl_chk import itw_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [OFF_W-1:0] host_off,
    input logic [31:0]      host_wdata,
    input logic             busy,
    input logic             start,
    input logic             fin,
    input logic             wr_en,
    input logic [4:0]       wr_word,
    input logic [15:0]      addr_q,
    input logic [3:0]       cmd_code,
    input logic [3:0]       done_bits,
    input logic             err_flag
);
    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (!busy && done_bits == $past(cmd_code)));

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (done_bits == 4'd0 && busy));

    // R4
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_word == $past(wr_word) + 5'd1));

    // R7
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && host_off == OFF_CMD) |=> err_flag);

    // R11
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(host_wr && host_off == OFF_STAT && host_wdata[STAT_ERR_BIT]));
endmodule

bind itw_ctrl itw_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
    .host_wdata(host_wdata), .busy(eng_busy), .start(start), .fin(eng_fin),
    .wr_en(wr_en), .wr_word(wr_word), .addr_q(16'(addr_q)),
    .cmd_code(cmd_code), .done_bits(done_bits), .err_flag(err_flag)
);

// File: tb/test_itw_ctrl.sv
module test_itw_ctrl;
    import itw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_off = 5'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic [5:0]  lk_region = 6'd0;
    logic [9:0]  lk_index = 10'd0;
    logic [4:0]  lk_word = 5'd0;
    logic [31:0] lk_data;
    logic        lk_req = 1'b0;
    logic        lk_req_q = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    itw_ctrl i_itw_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .lk_region(lk_region), .lk_index(lk_index), .lk_word(lk_word),
        .lk_data(lk_data)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench flop marking that a lookup was sampled at this edge
    always @(posedge clk) lk_req_q <= lk_req;

    // monitor: pop expected lookup results and compare
    always @(negedge clk) begin
        if (rst_n && lk_req_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(lk_data === e, t, lk_data, e);
        end
    end

    task automatic host_write(input logic [4:0] off, input logic [31:0] val);
        @(posedge clk); #1;
        host_wr = 1'b1; host_off = off; host_wdata = val;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] off, output logic [31:0] val);
        host_off = off;
        #1 val = host_rdata;
    endtask

    // driver: present a lookup and queue the expected word
    task automatic lookup(input logic [5:0] rgn, input logic [9:0] idx,
                          input logic [4:0] w, input logic [31:0] exp,
                          input string tag);
        @(posedge clk); #1;
        lk_region = rgn; lk_index = idx; lk_word = w; lk_req = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        lk_req = 1'b0;
    endtask

    function automatic logic [31:0] mk_addr(input logic [5:0] rgn, input logic [9:0] idx);
        return {16'd0, rgn, idx};
    endfunction

    task automatic run_cmd(input logic [31:0] addr, input int nw,
                           input logic [31:0] base, input logic [3:0] code,
                           input int exp_cyc, input logic exp_err,
                           input string tag);
        logic [31:0] st;
        int got;
        host_write(OFF_ADDR, addr);
        for (int i = 0; i < nw; i++) host_write(5'(int'(OFF_DATA0) + i), base + 32'(i));
        host_write(OFF_CMD, {28'd0, code});
        read_reg(OFF_STAT, st);
        chk(st[3:0] == 4'd0 && st[8], {tag, " R6 done cleared on accept"}, st, 32'h100);
        got = -1;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            read_reg(OFF_STAT, st);
            if (st[3:0] != 4'd0 || !st[8]) begin
                got = k;
                break;
            end
        end
        chk(got == exp_cyc, {tag, " R5 completion latency"}, 32'(got), 32'(exp_cyc));
        chk(st[3:0] == code && !st[8], {tag, " R5 done code"}, st, {28'd0, code});
        chk(st[9] == exp_err, {tag, " error flag"}, 32'(st[9]), 32'(exp_err));
    endtask

    task automatic clear_err();
        logic [31:0] st;
        host_write(OFF_STAT, 32'h200);
        read_reg(OFF_STAT, st);
        chk(st[9] == 1'b0, "R10 write-one clears error", st, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] st;
        repeat (3) @(posedge clk);
        #1;
        read_reg(OFF_STAT, st);
        chk(st == 32'd0, "R1 status in reset", st, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        read_reg(OFF_STAT, st);
        chk(st == 32'd0, "R1 status after reset", st, 32'd0);
        read_reg(OFF_ADDR, st);
        chk(st == 32'd0, "R1 address after reset", st, 32'd0);

        // R2: indirection entries on each port, sideband on port 1
        run_cmd(mk_addr(6'd1, 10'd5), 1, 32'hA5A5_0001, 4'h1, 1, 1'b0, "R2 idt p0");
        run_cmd(mk_addr(6'd5, 10'd5), 1, 32'h5A5A_0002, 4'h1, 1, 1'b0, "R2 idt p1");
        run_cmd(mk_addr(6'd1, 10'd0), 1, 32'h1111_0000, 4'h1, 1, 1'b0, "R2 idt p0 i0");
        run_cmd(mk_addr(6'd4, 10'd2), 1, 32'h5B00_0003, 4'h1, 1, 1'b0, "R2 sb p1");
        lookup(6'd1, 10'd5, 5'd0, 32'hA5A5_0001, "R2 R12 idt port0 copy");
        lookup(6'd5, 10'd5, 5'd0, 32'h5A5A_0002, "R2 R12 idt port1 copy");
        lookup(6'd4, 10'd2, 5'd0, 32'h5B00_0003, "R2 sb port1");

        // R4: hash key, four words on port 1
        run_cmd(mk_addr(6'd6, 10'd0), 4, 32'hBEE0_0000, 4'h1, 4, 1'b0, "R4 key p1");
        for (int w = 0; w < 4; w++)
            lookup(6'd6, 10'd0, 5'(w), 32'hBEE0_0000 + 32'(w), "R4 key word");

        // R3: shared tree node and result tables
        run_cmd(mk_addr(6'd32, 10'd3), 17, 32'hC000_0100, 4'h1, 17, 1'b0, "R3 node");
        lookup(6'd32, 10'd3, 5'd0,  32'hC000_0100, "R3 node word0");
        lookup(6'd32, 10'd3, 5'd8,  32'hC000_0108, "R3 node word8");
        lookup(6'd32, 10'd3, 5'd16, 32'hC000_0110, "R3 node word16");
        run_cmd(mk_addr(6'd33, 10'd7), 6, 32'hD000_0200, 4'h1, 6, 1'b0, "R3 res");
        lookup(6'd33, 10'd7, 5'd0, 32'hD000_0200, "R3 R4 res word0");
        lookup(6'd33, 10'd7, 5'd5, 32'hD000_0205, "R3 R4 res word5");

        // R8: invalid type, absent port, index beyond depth
        run_cmd(mk_addr(6'd3, 10'd0), 1, 32'hEEEE_0000, 4'h1, 1, 1'b1, "R8 type3");
        clear_err();
        run_cmd(mk_addr(6'd9, 10'd0), 1, 32'hEEEE_0001, 4'h1, 1, 1'b1, "R8 port2");
        clear_err();
        run_cmd(mk_addr(6'd1, 10'd16), 1, 32'hEEEE_0002, 4'h1, 1, 1'b1, "R8 idx16");
        lookup(6'd1, 10'd0, 5'd0, 32'h1111_0000, "R8 idx0 not aliased");

        // R10: status write without bit 9 keeps the error
        host_write(OFF_STAT, 32'h0);
        read_reg(OFF_STAT, st);
        chk(st[9] == 1'b1, "R10 error sticky", st, 32'h200);
        clear_err();

        // R9: unsupported command code
        run_cmd(mk_addr(6'd1, 10'd0), 1, 32'h2222_0000, 4'h2, 1, 1'b1, "R9 code2");
        lookup(6'd1, 10'd0, 5'd0, 32'h1111_0000, "R9 no write");
        clear_err();

        // R7 and R11: command and data writes during a transfer
        host_write(OFF_ADDR, mk_addr(6'd32, 10'd4));
        for (int i = 0; i < 17; i++) host_write(5'(int'(OFF_DATA0) + i), 32'hF000_0000 + 32'(i));
        host_write(OFF_CMD, 32'h1);
        host_write(OFF_CMD, 32'h1);
        host_write(OFF_DATA0, 32'hDEAD_DEAD);
        host_write(OFF_ADDR, mk_addr(6'd33, 10'd0));
        read_reg(OFF_ADDR, st);
        chk(st == mk_addr(6'd32, 10'd4), "R11 address frozen while busy", st, mk_addr(6'd32, 10'd4));
        for (int k = 0; k < 40; k++) begin
            read_reg(OFF_STAT, st);
            if (!st[8]) break;
            @(posedge clk); #1;
        end
        chk(st[3:0] == 4'h1 && !st[8], "R7 first command completes", st, 32'h201);
        chk(st[9] == 1'b1, "R7 error on busy command", st, 32'h201);
        lookup(6'd32, 10'd4, 5'd0,  32'hF000_0000, "R11 data0 unchanged");
        lookup(6'd32, 10'd4, 5'd16, 32'hF000_0010, "R7 last word");
        lookup(6'd32, 10'd3, 5'd16, 32'hC000_0110, "R3 other node entry");
        clear_err();

        repeat (4) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R12 all lookups answered", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule